// File: doc/BRIEF.md
# Special-purpose register access decoder

This block serves move-to and move-from operations on the group-0 special-purpose registers of a small 32-bit processor. A request carries a base operand and a 16-bit immediate offset. The block forms the register number as the bitwise OR of the two. Bits 15:11 of that number select the group and bits 10:0 select the index.

Writes update one of seven writable registers:

- the version word
- the next and previous program counters
- the status word
- the exception program counter
- the exception effective address
- the exception status

Four read-only configuration words are also visible. Writes to them change nothing. A read returns the selected value one cycle after the request. The version word is masked on the way out. Any number the block does not implement returns the old destination-register value that came with the request.

The status word drives two level outputs, the data and instruction translation enables. A status write that changes either enable, or the supervisor bit, produces a one-cycle translation flush pulse. Every status write forces the fixed-one bit (bit 15) to 1.

A three-state machine sequences the responses:

- `ST_IDLE`: no response.
- `ST_RDATA`: read data valid.
- `ST_WDONE`: write committed; the flush pulse may show here.

Transitions are taken on every clock:

- A read request goes to `ST_RDATA`.
- A write request goes to `ST_WDONE`.
- No request goes to `ST_IDLE`.

All three transitions apply from any state, so requests may come back to back.

Top module: `spr_access_unit`

## Requirements
- R1: The register number is `req_base | zero-extended req_offset`. Bits 15:11 are the group and bits 10:0 are the index. A number with any of bits 31:16 set is unimplemented.
- R2: After reset:
  - `rsp_valid`, `flush_pulse`, `dmmu_en` and `immu_en` are 0.
  - Status reads 0x00008001.
  - The version word holds `VER_RESET`.
  - The other writable registers hold 0.
- R3: In group 0, indices 16, 18, 32, 48 and 64 (next PC, previous PC, exception PC, exception address, exception status) read back the last value written to them, unchanged.
- R4: Group-0 indices 1, 2, 3 and 4 read the parameters `UNITS_WORD`, `CORE_WORD`, `DXL_WORD` and `IXL_WORD`. Writes to them have no effect.
- R5: A write to status (group 0, index 17) stores the written value with bit 15 forced to 1.
- R6: `flush_pulse` is 1 in the cycle after a status write exactly when the write changes bit 0 (supervisor), bit 5 (instruction translation enable) or bit 6 (data translation enable) of status. Otherwise it is 0.
- R7: A read of the version word (group 0, index 0) returns the stored value ANDed with `VER_MASK`.
- R8: A read of any unimplemented number returns `req_dest` unchanged. This includes group-0 indices not listed in R3 to R7 and every index of groups 1 to 31.
- R9: `dmmu_en` equals status bit 6 and `immu_en` equals status bit 5. Both change only after a write.
- R10: A read accepted at a clock edge gives `rsp_valid` = 1 with its data for the following cycle. A write never raises `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_base | input | 32 | Base operand |
| req_offset | input | 16 | Immediate offset |
| req_wdata | input | 32 | Write data |
| req_dest | input | 32 | Old destination-register value |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| flush_pulse | output | 1 | One-cycle translation flush |
| dmmu_en | output | 1 | Data translation enable level |
| immu_en | output | 1 | Instruction translation enable level |

## Verification
A corrupted status word shows up at once at the ports: a wrong enable appears on `dmmu_en` or `immu_en` in the cycle after the write, and the next read of status returns a wrong word. A wrong change detector shows as a flush pulse that is missing or spurious in the cycle right after a status write. The bench covers all 64 transitions between the eight combinations of the three control bits. A wrong number decode shows in the response cycle of a single read: the data comes from the wrong register, or the destination value is passed through when it should not be. The bench sweeps all of group 0's lower indices and a fixed index in every other group to catch this.

// File: rtl/spr_pkg.sv
package spr_pkg;
    localparam int GRP_LSB = 11;
    localparam int GRP_W   = 5;

    typedef logic [GRP_LSB-1:0] spr_idx_t;

    localparam spr_idx_t IDX_VERSION = spr_idx_t'(0);
    localparam spr_idx_t IDX_UNITS   = spr_idx_t'(1);
    localparam spr_idx_t IDX_CORECFG = spr_idx_t'(2);
    localparam spr_idx_t IDX_DXLCFG  = spr_idx_t'(3);
    localparam spr_idx_t IDX_IXLCFG  = spr_idx_t'(4);
    localparam spr_idx_t IDX_NEXTPC  = spr_idx_t'(16);
    localparam spr_idx_t IDX_STATUS  = spr_idx_t'(17);
    localparam spr_idx_t IDX_PREVPC  = spr_idx_t'(18);
    localparam spr_idx_t IDX_EXCPC   = spr_idx_t'(32);
    localparam spr_idx_t IDX_EXCADDR = spr_idx_t'(48);
    localparam spr_idx_t IDX_EXCSTAT = spr_idx_t'(64);

    localparam int SB_SUPER = 0;
    localparam int SB_IXL   = 5;
    localparam int SB_DXL   = 6;
    localparam int SB_ONE   = 15;

    localparam int NUM_PLAIN = 6;
    localparam int SLOT_W    = $clog2(NUM_PLAIN);

    typedef enum logic [3:0] {
        SEL_VERSION,
        SEL_UNITS,
        SEL_CORECFG,
        SEL_DXLCFG,
        SEL_IXLCFG,
        SEL_NEXTPC,
        SEL_STATUS,
        SEL_PREVPC,
        SEL_EXCPC,
        SEL_EXCADDR,
        SEL_EXCSTAT,
        SEL_NONE
    } spr_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RDATA,
        ST_WDONE
    } rsp_state_e;
endpackage

// File: rtl/spr_num_dec.sv
module spr_num_dec
    import spr_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OFS_W = 16
) (
    input  logic [XLEN-1:0]  base,
    input  logic [OFS_W-1:0] offset,
    output spr_sel_e         sel
);
    localparam int NUM_W = GRP_LSB + GRP_W;

    logic [XLEN-1:0]  num;
    logic             hi_clear;
    logic [GRP_W-1:0] group;
    spr_idx_t         idx;

    assign num      = base | XLEN'(offset);
    assign hi_clear = (num[XLEN-1:NUM_W] == '0);
    assign group    = num[NUM_W-1:GRP_LSB];
    assign idx      = num[GRP_LSB-1:0];

    always_comb begin
        sel = SEL_NONE;
        if (hi_clear && group == '0) begin
            case (idx)
                IDX_VERSION: sel = SEL_VERSION;
                IDX_UNITS:   sel = SEL_UNITS;
                IDX_CORECFG: sel = SEL_CORECFG;
                IDX_DXLCFG:  sel = SEL_DXLCFG;
                IDX_IXLCFG:  sel = SEL_IXLCFG;
                IDX_NEXTPC:  sel = SEL_NEXTPC;
                IDX_STATUS:  sel = SEL_STATUS;
                IDX_PREVPC:  sel = SEL_PREVPC;
                IDX_EXCPC:   sel = SEL_EXCPC;
                IDX_EXCADDR: sel = SEL_EXCADDR;
                IDX_EXCSTAT: sel = SEL_EXCSTAT;
                default:     sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/spr_status_reg.sv
module spr_status_reg
    import spr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] status,
    output logic            ctrl_change
);
    localparam logic [XLEN-1:0] ONE_MASK  = XLEN'(1) << SB_ONE;
    localparam logic [XLEN-1:0] CTRL_MASK = (XLEN'(1) << SB_SUPER)
                                          | (XLEN'(1) << SB_IXL)
                                          | (XLEN'(1) << SB_DXL);
    localparam logic [XLEN-1:0] RST_VAL   = ONE_MASK | (XLEN'(1) << SB_SUPER);

    logic [XLEN-1:0] status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= RST_VAL;
        end else if (wr_en) begin
            status_q <= wdata | ONE_MASK;
        end
    end

    assign status      = status_q;
    assign ctrl_change = wr_en && (((status_q ^ wdata) & CTRL_MASK) != '0);

    AST_FIXED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[SB_ONE]); // R5
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(status_q)); // R9
endmodule

// File: rtl/spr_plain_regs.sv
module spr_plain_regs
    import spr_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              NREG      = NUM_PLAIN,
    parameter logic [XLEN-1:0] VER_RESET = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SLOT_W-1:0]        wr_slot,
    input  logic [XLEN-1:0]          wdata,
    output logic [NREG-1:0][XLEN-1:0] q
);
    for (genvar s = 0; s < NREG; s++) begin : g_slot
        localparam logic [XLEN-1:0] RST = (s == 0) ? VER_RESET : '0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[s] <= RST;
            end else if (wr_en && wr_slot == SLOT_W'(s)) begin
                q[s] <= wdata;
            end
        end
    end
endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
    import spr_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              OFS_W      = 16,
    parameter logic [XLEN-1:0] VER_RESET  = 32'h1200_0001,
    parameter logic [XLEN-1:0] VER_MASK   = 32'hFF00_00FF,
    parameter logic [XLEN-1:0] UNITS_WORD = 32'h0000_0781,
    parameter logic [XLEN-1:0] CORE_WORD  = 32'h0000_0020,
    parameter logic [XLEN-1:0] DXL_WORD   = 32'h0000_0004,
    parameter logic [XLEN-1:0] IXL_WORD   = 32'h0000_0008
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [XLEN-1:0]  req_base,
    input  logic [OFS_W-1:0] req_offset,
    input  logic [XLEN-1:0]  req_wdata,
    input  logic [XLEN-1:0]  req_dest,
    output logic             rsp_valid,
    output logic [XLEN-1:0]  rsp_data,
    output logic             flush_pulse,
    output logic             dmmu_en,
    output logic             immu_en
);
    spr_sel_e                      sel;
    logic                          rd_req, wr_req;
    logic                          status_we, plain_we, ctrl_change;
    logic [XLEN-1:0]               status;
    logic [NUM_PLAIN-1:0][XLEN-1:0] plain_q;
    logic [SLOT_W-1:0]             slot;
    logic                          is_plain;
    logic [XLEN-1:0]               rd_val;
    rsp_state_e                    state_q, state_d;
    logic [XLEN-1:0]               rsp_data_q;
    logic                          flush_q;

    assign rd_req = req_valid && !req_write;
    assign wr_req = req_valid && req_write;

    spr_num_dec #(.XLEN(XLEN), .OFS_W(OFS_W)) u_dec (
        .base   (req_base),
        .offset (req_offset),
        .sel    (sel)
    );

    always_comb begin
        is_plain = 1'b1;
        slot     = '0;
        case (sel)
            SEL_VERSION: slot = SLOT_W'(0);
            SEL_NEXTPC:  slot = SLOT_W'(1);
            SEL_PREVPC:  slot = SLOT_W'(2);
            SEL_EXCPC:   slot = SLOT_W'(3);
            SEL_EXCADDR: slot = SLOT_W'(4);
            SEL_EXCSTAT: slot = SLOT_W'(5);
            default:     is_plain = 1'b0;
        endcase
    end

    assign status_we = wr_req && (sel == SEL_STATUS);
    assign plain_we  = wr_req && is_plain;

    spr_status_reg #(.XLEN(XLEN)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (status_we),
        .wdata       (req_wdata),
        .status      (status),
        .ctrl_change (ctrl_change)
    );

    spr_plain_regs #(.XLEN(XLEN), .NREG(NUM_PLAIN), .VER_RESET(VER_RESET)) u_plain (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (plain_we),
        .wr_slot (slot),
        .wdata   (req_wdata),
        .q       (plain_q)
    );

    always_comb begin
        unique case (sel)
            SEL_VERSION: rd_val = plain_q[0] & VER_MASK;
            SEL_UNITS:   rd_val = UNITS_WORD;
            SEL_CORECFG: rd_val = CORE_WORD;
            SEL_DXLCFG:  rd_val = DXL_WORD;
            SEL_IXLCFG:  rd_val = IXL_WORD;
            SEL_NEXTPC:  rd_val = plain_q[1];
            SEL_STATUS:  rd_val = status;
            SEL_PREVPC:  rd_val = plain_q[2];
            SEL_EXCPC:   rd_val = plain_q[3];
            SEL_EXCADDR: rd_val = plain_q[4];
            SEL_EXCSTAT: rd_val = plain_q[5];
            SEL_NONE:    rd_val = req_dest;
            default:     rd_val = req_dest;
        endcase
    end

    // next-state selection
    always_comb begin
        if (rd_req) begin
            state_d = ST_RDATA;
        end else if (wr_req) begin
            state_d = ST_WDONE;
        end else begin
            state_d = ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // response payload registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_data_q <= '0;
            flush_q    <= 1'b0;
        end else begin
            if (rd_req) begin
                rsp_data_q <= rd_val;
            end
            flush_q <= status_we && ctrl_change;
        end
    end

    // outputs
    always_comb begin
        rsp_valid   = 1'b0;
        flush_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_RDATA: rsp_valid = 1'b1;
            ST_WDONE: flush_pulse = flush_q;
            default:  ;
        endcase
    end

    assign rsp_data = rsp_data_q;
    assign dmmu_en  = status[SB_DXL];
    assign immu_en  = status[SB_IXL];

    AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> $past(req_valid && req_write)); // R6
    AST_RSP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write)); // R10
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_valid); // R10
    AST_MMU_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> $stable({dmmu_en, immu_en})); // R9
endmodule

// File: tb/spr_access_unit_test.sv
module spr_access_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] VER_RESET  = 32'h1200_0001;
    localparam logic [31:0] VER_MASK   = 32'hFF00_00FF;
    localparam logic [31:0] UNITS_WORD = 32'h0000_0781;
    localparam logic [31:0] CORE_WORD  = 32'h0000_0020;
    localparam logic [31:0] DXL_WORD   = 32'h0000_0004;
    localparam logic [31:0] IXL_WORD   = 32'h0000_0008;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_base = '0, req_wdata = '0, req_dest = '0;
    logic [15:0] req_offset = '0;
    logic        rsp_valid, flush_pulse, dmmu_en, immu_en;
    logic [31:0] rsp_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] m_ver = VER_RESET, m_npc = '0, m_ppc = '0, m_epc = '0;
    logic [31:0] m_eear = '0, m_esr = '0, m_sr = 32'h0000_8001;

    always #(CLK_PERIOD/2) clk = ~clk;

    spr_access_unit #(
        .VER_RESET(VER_RESET), .VER_MASK(VER_MASK), .UNITS_WORD(UNITS_WORD),
        .CORE_WORD(CORE_WORD), .DXL_WORD(DXL_WORD), .IXL_WORD(IXL_WORD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
        .req_dest(req_dest), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .flush_pulse(flush_pulse), .dmmu_en(dmmu_en), .immu_en(immu_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [31:0] num, input logic [31:0] dest);
        if (num[31:16] != 0 || num[15:11] != 0) return dest;
        case (num[10:0])
            11'd0:   return m_ver & VER_MASK;
            11'd1:   return UNITS_WORD;
            11'd2:   return CORE_WORD;
            11'd3:   return DXL_WORD;
            11'd4:   return IXL_WORD;
            11'd16:  return m_npc;
            11'd17:  return m_sr;
            11'd18:  return m_ppc;
            11'd32:  return m_epc;
            11'd48:  return m_eear;
            11'd64:  return m_esr;
            default: return dest;
        endcase
    endfunction

    task automatic model_write(input logic [31:0] num, input logic [31:0] d);
        if (num[31:11] == 0) begin
            case (num[10:0])
                11'd0:  m_ver = d;
                11'd16: m_npc = d;
                11'd17: m_sr = d | 32'h0000_8000;
                11'd18: m_ppc = d;
                11'd32: m_epc = d;
                11'd48: m_eear = d;
                11'd64: m_esr = d;
                default: ;
            endcase
        end
    endtask

    task automatic do_write(input logic [31:0] b, input logic [15:0] o, input logic [31:0] d);
        logic [31:0] num;
        logic exp_flush;
        num = b | {16'h0, o};
        exp_flush = (num == 32'd17) && (((m_sr ^ d) & 32'h0000_0061) != 0);
        model_write(num, d);
        req_valid = 1'b1; req_write = 1'b1; req_base = b; req_offset = o; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R6 flush after write", {31'h0, flush_pulse}, {31'h0, exp_flush});
        check("R10 no rsp on write", {31'h0, rsp_valid}, 32'h0);
        check("R9 dmmu_en", {31'h0, dmmu_en}, {31'h0, m_sr[6]});
        check("R9 immu_en", {31'h0, immu_en}, {31'h0, m_sr[5]});
        @(negedge clk);
        check("R6 flush single cycle", {31'h0, flush_pulse}, 32'h0);
    endtask

    task automatic do_read(input string tag, input logic [31:0] b, input logic [15:0] o,
                           input logic [31:0] dest);
        logic [31:0] exp;
        exp = model_read(b | {16'h0, o}, dest);
        req_valid = 1'b1; req_write = 1'b0; req_base = b; req_offset = o; req_dest = dest;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R10 rsp_valid"}, {31'h0, rsp_valid}, 32'h1);
        check(tag, rsp_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired act=%h exp=%h", 32'h1, 32'h0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        check("R2 rsp_valid reset", {31'h0, rsp_valid}, 32'h0);
        check("R2 flush reset", {31'h0, flush_pulse}, 32'h0);
        check("R2 dmmu_en reset", {31'h0, dmmu_en}, 32'h0);
        check("R2 immu_en reset", {31'h0, immu_en}, 32'h0);
        do_read("R2 status reset", 32'h0, 16'd17, 32'hDEAD_0001);
        check("R2 status value", rsp_data, 32'h0000_8001);
        do_read("R7 version reset masked", 32'h0, 16'd0, 32'h0);
        check("R7 version value", rsp_data, VER_RESET & VER_MASK);
        do_read("R2 next pc reset", 32'h0, 16'd16, 32'hFFFF_FFFF);
        check("R2 next pc zero", rsp_data, 32'h0);

        // R1 address formation
        do_write(32'h10, 16'h0, 32'hA5A5_1234);
        do_read("R1 offset only", 32'h0, 16'h10, 32'h0);
        check("R1 value", rsp_data, 32'hA5A5_1234);
        do_read("R1 or of base and offset", 32'h10, 16'h01, 32'h0);
        check("R1 status via or", rsp_data, m_sr);
        do_read("R1 upper bits set", 32'h0001_0000, 16'd16, 32'h1357_9BDF);
        check("R1 upper bits dest", rsp_data, 32'h1357_9BDF);
        do_read("R8 group1 idx16", 32'h800, 16'd16, 32'h2468_ACE0);

        // R3 plain registers
        do_write(32'h0, 16'd16, 32'h0000_1000);
        do_write(32'h0, 16'd18, 32'h0000_2004);
        do_write(32'h20, 16'h0, 32'hCAFE_F00D);
        do_write(32'h0, 16'd48, 32'h8000_0001);
        do_write(32'h40, 16'h0, 32'h0F0F_0F0F);
        do_write(32'h0, 16'd0, 32'hFFFF_FFFF);
        do_read("R7 version after write", 32'h0, 16'd0, 32'h0);
        check("R7 version masked", rsp_data, VER_MASK);

        // R4 config writes ignored
        for (int i = 1; i <= 4; i++) do_write(32'h0, 16'(i), 32'hFFFF_FFFF);

        // sweep group 0 indices (R3 R4 R8)
        for (int i = 0; i < 128; i++)
            do_read("R3 R4 R8 group0 sweep", 32'h0, 16'(i), 32'h5A00_0000 + 32'(i));
        // sweep other groups (R8)
        for (int g = 1; g < 32; g++)
            do_read("R8 other group sweep", 32'(g) << 11, 16'd17, 32'h7700_0000 + 32'(g));

        // R5 R6 R9 status transitions
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                logic [31:0] va, vb;
                va = {25'h0, a[2], a[1], 4'h0, a[0]} | 32'h0000_0F00;
                vb = {25'h0, b[2], b[1], 4'h0, b[0]} | 32'h0000_3000;
                do_write(32'h0, 16'd17, va);
                do_write(32'h0, 16'd17, vb);
                do_read("R5 status fixed one", 32'h0, 16'd17, 32'h0);
                check("R5 bit15 set", {31'h0, rsp_data[15]}, 32'h1);
            end
        end

        // back-to-back reads (R10)
        req_valid = 1'b1; req_write = 1'b0; req_base = 32'h0; req_offset = 16'd32;
        @(negedge clk);
        check("R10 first of pair", rsp_data, m_epc);
        req_offset = 16'd64;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 second of pair valid", {31'h0, rsp_valid}, 32'h1);
        check("R10 second of pair", rsp_data, m_esr);
        @(negedge clk);
        check("R10 idle after reads", {31'h0, rsp_valid}, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule